// File: doc/BRIEF.md
# Accumulator Rounding and Output Narrowing

This block owns a wide accumulator register and produces a narrower result taken from the register's upper bits. The low bits that fall below the output are treated as a binary fraction. Each cycle an operation is chosen. It either loads the register without change, which truncates the fraction at the output, or it rounds the operand by sending a rounding constant and a carry through the register's own adder. No saturation is applied. Sums wrap modulo two to the power of the accumulator width.

The operand can be an upstream accumulator value, a cascade value from a neighbouring slice, or the block's own register. Two rounding flavours are offered:

- **Simple rounding** adds a constant just below one half. An external carry can raise that constant to exactly one half, which allows randomised rounding when the carry is driven from a noise source.
- **Symmetric rounding** adds the same constant plus the inverse of the operand's sign bit. This gives round-half-away-from-zero.

The fraction bits that remain after the add are kept in the register and are not cleared.

Top module: `acc_round_narrow`

## Requirements
- R1: A synchronous active-high `rst` clears the register, so `p_full` and `rnd_out` read zero on the cycle after a reset edge.
- R2: Every operation is registered: `p_full` shows the result of the operands presented at a rising edge just after that edge, one cycle after issue.
- R3: Mode 0 (truncate) loads the selected operand unchanged and ignores `carry_in`.
- R4: Mode 1 (simple round) with `carry_in` low adds 2^(FRAC_W-1)-1. A value of +x.5 therefore yields x, and -x.5 yields -x-1.
- R5: Mode 1 with `carry_in` high adds exactly 2^(FRAC_W-1), one half of an output LSB.
- R6: Mode 2 (symmetric round) adds 2^(FRAC_W-1)-1 plus one when the operand's top bit is 0. A value of +x.5 therefore yields x+1, and -x.5 yields -x-1. This mode ignores `carry_in`.
- R7: `rnd_out` equals bits [ACC_W-1:FRAC_W] of the register, where FRAC_W = ACC_W - OUT_W. The low FRAC_W bits of the sum stay in the register, visible on `p_full`.
- R8: `src_sel` picks the operand: 0 selects `acc_in`, 1 selects `casc_in`, 2 selects the register itself, and 3 selects zero.
- R9: Sums wrap modulo 2^ACC_W with no saturation.
- R10: Mode 3 behaves exactly as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 0 truncate, 1 simple round, 2 symmetric round, 3 truncate |
| src_sel | input | 2 | Operand: 0 `acc_in`, 1 `casc_in`, 2 own register, 3 zero |
| carry_in | input | 1 | External carry used by simple rounding |
| acc_in | input | ACC_W | Upstream accumulator value |
| casc_in | input | ACC_W | Cascade value from a neighbouring slice |
| p_full | output | ACC_W | Full register contents, including the retained fraction |
| rnd_out | output | OUT_W | Narrowed result, the upper OUT_W bits of the register |

## Verification
Directed operands sit exactly on +x.5 and -x.5, and just either side of them. These cases separate simple rounding from symmetric rounding and show where the external carry moves the tie. Values at the largest positive and negative extremes show the wrap, and back-to-back rounding of the register's own value shows that the retained fraction feeds forward. A long random run with every mode, source and carry combination is compared each cycle against a behavioural model. That run exposes wrong operand codes and any place where the carry leaks into truncation.

// File: rtl/acc_round_narrow.sv
module acc_round_narrow #(
  parameter int ACC_W = 48,
  parameter int OUT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic [1:0]       src_sel,
  input  logic             carry_in,
  input  logic [ACC_W-1:0] acc_in,
  input  logic [ACC_W-1:0] casc_in,
  output logic [ACC_W-1:0] p_full,
  output logic [OUT_W-1:0] rnd_out
);
  localparam int FRAC_W = ACC_W - OUT_W;
  localparam logic [ACC_W-1:0] NEAR_HALF = (ACC_W'(1) << (FRAC_W - 1)) - ACC_W'(1);
  localparam logic [1:0] M_TRUNC = 2'd0, M_SIMPLE = 2'd1, M_SYM = 2'd2;
  localparam logic [1:0] S_ACC = 2'd0, S_CASC = 2'd1, S_SELF = 2'd2;

  logic [ACC_W-1:0] p_reg, opnd, addend, nxt;
  logic             cy;

  always_comb begin
    case (src_sel)
      S_ACC:   opnd = acc_in;
      S_CASC:  opnd = casc_in;
      S_SELF:  opnd = p_reg;
      default: opnd = '0;
    endcase
  end

  always_comb begin
    case (mode)
      M_SIMPLE: begin addend = NEAR_HALF; cy = carry_in;         end
      M_SYM:    begin addend = NEAR_HALF; cy = ~opnd[ACC_W-1];   end
      default:  begin addend = '0;        cy = 1'b0;             end
    endcase
  end

  assign nxt = opnd + addend + ACC_W'(cy);

  always_ff @(posedge clk) begin
    if (rst) p_reg <= '0;
    else     p_reg <= nxt;
  end

  assign p_full  = p_reg;
  assign rnd_out = p_reg[ACC_W-1:FRAC_W];

  p_trunc_self_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ((mode == M_TRUNC || mode == 2'd3) && src_sel == S_SELF) |=> $stable(p_full))
    else $error("truncate of own register changed it");

  p_trunc_load_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == M_TRUNC && src_sel == S_ACC) |=> (p_full == $past(acc_in)))
    else $error("truncate load mismatch");

  p_simple_step_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == M_SIMPLE && src_sel == S_SELF && !carry_in) |=>
      (p_full - $past(p_full) == NEAR_HALF))
    else $error("simple round step wrong");

  p_sym_pos_step_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == M_SYM && src_sel == S_SELF && !p_full[ACC_W-1]) |=>
      (p_full - $past(p_full) == NEAR_HALF + ACC_W'(1)))
    else $error("symmetric round of positive value wrong");

  p_zero_src_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == M_TRUNC && src_sel == 2'd3) |=> (p_full == '0))
    else $error("zero operand not zero");
endmodule

// File: tb/test_acc_round_narrow.sv
`timescale 1ns/1ps
module test_acc_round_narrow;
  localparam int AW = 48, OW = 18, FW = AW - OW;
  logic clk = 0, rst = 1, carry_in = 0;
  logic [1:0] mode = 0, src_sel = 0;
  logic [AW-1:0] acc_in = 0, casc_in = 0, p_full;
  logic [OW-1:0] rnd_out;
  logic [AW-1:0] model_p = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  acc_round_narrow #(.ACC_W(AW), .OUT_W(OW)) i_acc_round_narrow (
    .clk(clk), .rst(rst), .mode(mode), .src_sel(src_sel), .carry_in(carry_in),
    .acc_in(acc_in), .casc_in(casc_in), .p_full(p_full), .rnd_out(rnd_out));

  function automatic logic [AW-1:0] ref_next(logic [1:0] m, logic [1:0] s, logic c,
                                             logic [AW-1:0] a, logic [AW-1:0] k, logic [AW-1:0] p);
    logic [AW-1:0] v;
    longint unsigned half_m1;
    half_m1 = (64'd1 << (FW - 1)) - 1;
    v = (s == 0) ? a : (s == 1) ? k : (s == 2) ? p : '0;
    if (m == 1) return v + AW'(half_m1) + AW'(c);
    if (m == 2) return v + AW'(half_m1) + AW'(!v[AW-1]);
    return v;
  endfunction

  task automatic check(string tag, logic [AW-1:0] got, logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step(string tag, logic [1:0] m, logic [1:0] s, logic c,
                      logic [AW-1:0] a, logic [AW-1:0] k);
    logic [AW-1:0] exp;
    mode = m; src_sel = s; carry_in = c; acc_in = a; casc_in = k;
    exp = ref_next(m, s, c, a, k, model_p);
    @(negedge clk);
    model_p = exp;
    check(tag, p_full, model_p);
    check({tag, " out"}, AW'(rnd_out), AW'(model_p[AW-1:FW]));
  endtask

  task automatic out_is(string tag, int v);
    logic [OW-1:0] e;
    e = OW'(v);
    check(tag, AW'(rnd_out), AW'(e));
  endtask

  function automatic logic [AW-1:0] fx(int whole, int quarters);
    return (AW'(signed'(whole)) << FW) + (AW'(signed'(quarters)) << (FW - 2));
  endfunction

  initial begin
    @(negedge clk);
    acc_in = '1; casc_in = '1; mode = 1; carry_in = 1;
    repeat (3) @(negedge clk);
    check("R1 reset", p_full, '0);
    out_is("R1 reset out", 0);
    rst = 0;

    step("R2 load", 0, 0, 1, fx(7, 1), 0);
    out_is("R3 trunc 7.25", 7);
    step("R3 trunc carry ignored", 0, 0, 1, fx(-3, -1), 0);
    out_is("R3 trunc -3.25", -4);
    step("R10 mode3", 3, 1, 1, 0, fx(9, 3));
    out_is("R10 mode3 trunc", 9);

    step("R4 simple +5.5", 1, 0, 0, fx(5, 2), 0);
    out_is("R4 +5.5 -> 5", 5);
    step("R4 simple -5.5", 1, 0, 0, fx(-5, -2), 0);
    out_is("R4 -5.5 -> -6", -6);
    step("R4 simple 5.75", 1, 1, 0, 0, fx(5, 3));
    out_is("R4 5.75 -> 6", 6);
    step("R5 simple carry +5.5", 1, 0, 1, fx(5, 2), 0);
    out_is("R5 +5.5 carry -> 6", 6);
    step("R5 simple carry -5.5", 1, 0, 1, fx(-5, -2), 0);
    out_is("R5 -5.5 carry -> -5", -5);

    step("R6 sym +5.5", 2, 0, 0, fx(5, 2), 0);
    out_is("R6 +5.5 -> 6", 6);
    step("R6 sym -5.5", 2, 1, 1, 0, fx(-5, -2));
    out_is("R6 -5.5 -> -6", -6);
    step("R6 sym -5.25", 2, 0, 0, fx(-5, -1), 0);
    out_is("R6 -5.25 -> -5", -5);

    step("R7 retain load", 0, 0, 0, fx(2, 1), 0);
    step("R7 retain round self", 1, 2, 0, 0, 0);
    check("R7 fraction kept", AW'(p_full[FW-1:0]), AW'((64'd1 << (FW - 2)) + (64'd1 << (FW - 1)) - 1));
    step("R8 self sym", 2, 2, 0, 0, 0);
    step("R8 zero src", 0, 3, 1, '1, '1);
    check("R8 zero", p_full, '0);

    step("R9 wrap", 2, 0, 0, {1'b0, {(AW-1){1'b1}}}, 0);
    check("R9 wrapped negative", AW'(p_full[AW-1]), AW'(1));

    for (int i = 0; i < 400; i++)
      step("R2 random", 2'($urandom), 2'($urandom), 1'($urandom),
           {$urandom, $urandom}, {$urandom, $urandom});

    rst = 1;
    step_reset();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic step_reset();
    @(negedge clk);
    model_p = 0;
    check("R1 reset again", p_full, '0);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R2 got=hang exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule